// File: doc/BRIEF.md
# I2C Wiper Register Slave

This block is the serial front end of a two-channel trim control. A system clock samples the I2C clock and data lines, and the block decodes START, repeated START and STOP. It answers an identification byte whose upper four bits are fixed and whose next three bits come from strap inputs. It then accepts a register pointer and either stores incoming data bytes or returns register contents to the master. The register file holds two 8-bit wiper positions and one control register that carries a shutdown flag. The register contents drive the analog side directly.

The data line is driven only low, through an open-drain enable. Each line passes through a two-flop synchronizer and a stability filter before edges are taken, so single-cycle spikes never reach the protocol logic. The pointer moves forward one register after each data byte, from wiper 0 to wiper 1. It then stays at wiper 1, so a multi-byte write covers both channels and a long read keeps returning wiper 1.

Top module: `wiper_i2c_slave`

## Requirements
- R1: The identification byte is sent MSB first and is 1010, then strap_i[2], strap_i[1], strap_i[0], then a direction bit (1 read, 0 write). A matching byte is ACKed by holding SDA low during the ninth clock. A byte that does not match gets no ACK, and the slave ignores the bus until the next START.
- R2: The register map is 00h wiper 0, 01h wiper 1 and 10h control. Any other address reads as 00h and discards writes, but its address and data bytes are still ACKed.
- R3: After reset, wiper0_o and wiper1_o are 80h and ctrl_o is 40h. Only bit 6 of the control register (shutdown) can be stored; its other bits always read 0.
- R4: The address byte and every write data byte are ACKed on their ninth clock.
- R5: A write data byte is committed to the addressed register at the rising SCL edge of that byte's ninth clock, and at no other time.
- R6: When more data bytes follow in one write, the pointer advances from 00h to 01h after a byte and otherwise stays where it is. Two bytes written from 00h therefore land in wiper 0 and wiper 1.
- R7: A read consists of a write-mode identification byte, an address byte, a repeated START, a read-mode identification byte, and then slave data sent MSB first. Each master ACK advances the pointer by the R6 rule, and a NACK ends the read.
- R8: The slave changes its SDA drive only while SCL is low.
- R9: After a STOP the slave releases SDA and ignores every byte until a new START.
- R10: A pulse on SDA or SCL that lasts fewer than STABLE_CYC system clocks is ignored. Such a pulse on SDA while SCL is high does not start or stop a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| strap_i | input | 3 | Strapped low bits of the device identification |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wiper0_o | output | 8 | Wiper 0 position |
| wiper1_o | output | 8 | Wiper 1 position |
| ctrl_o | output | 8 | Control register contents (bit 6 is shutdown) |

## Verification
A bus edge reaches the protocol logic about six system clocks after it appears on a pin: two for the synchronizer, three for the filter and one for edge detection. A committed register therefore shows on its output about eight clocks after the ninth SCL rise. The SDA drive moves about seven clocks after an SCL fall. The bench master holds every SCL phase for twelve clocks, so it samples ACK and read bits well after the slave has driven them. It reads register outputs only after the complete ACK bit, so every check falls in a settled window.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  localparam int unsigned DW = 8;
  localparam logic [3:0]    ID_PREFIX  = 4'b1010;
  localparam logic [DW-1:0] ADDR_W0    = 8'h00;
  localparam logic [DW-1:0] ADDR_W1    = 8'h01;
  localparam logic [DW-1:0] ADDR_CTRL  = 8'h10;
  localparam logic [DW-1:0] RST_WIPER  = 8'h80;
  localparam logic [DW-1:0] RST_CTRL   = 8'h40;
  localparam logic [DW-1:0] CTRL_MASK  = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADDR, ST_WDATA, ST_RDATA
  } bus_state_e;

  function automatic logic [DW-1:0] ptr_adv(input logic [DW-1:0] p);
    return (p == ADDR_W0) ? ADDR_W1 : p;
  endfunction
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned STABLE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(STABLE + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != out_q) begin
        if (cnt_q == CW'(STABLE - 1)) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/wiper_reg_bank.sv
module wiper_reg_bank
  import wiper_i2c_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] wiper0_o,
  output logic [DW-1:0] wiper1_o,
  output logic [DW-1:0] ctrl_o
);
  logic [DW-1:0] w0_q, w1_q, ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w0_q   <= RST_WIPER;
      w1_q   <= RST_WIPER;
      ctrl_q <= RST_CTRL;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_W0:   w0_q   <= wdata_i;
        ADDR_W1:   w1_q   <= wdata_i;
        ADDR_CTRL: ctrl_q <= wdata_i & CTRL_MASK;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W0:   rdata_o = w0_q;
      ADDR_W1:   rdata_o = w1_q;
      ADDR_CTRL: rdata_o = ctrl_q;
      default:   rdata_o = '0;
    endcase
  end

  assign wiper0_o = w0_q;
  assign wiper1_o = w1_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/i2c_wiper_engine.sv
module i2c_wiper_engine
  import wiper_i2c_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic [DW-1:0] rdata_i,
  output logic          we_o,
  output logic [DW-1:0] ptr_o,
  output logic [DW-1:0] wdata_o,
  output logic          sda_oe_o,
  output logic          stop_o
);
  bus_state_e    state_q;
  logic          scl_q, sda_q, ack_q, rw_q, mack_q, oe_q, we_q;
  logic [3:0]    cnt_q;
  logic [DW-1:0] sh_q, ptr_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      we_q  <= 1'b0;
      if (start_det) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        ack_q   <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (!ack_q) begin
              if (scl_rise) begin
                sh_q  <= {sh_q[DW-2:0], sda_i};
                cnt_q <= cnt_q + 1'b1;
              end else if (scl_fall && cnt_q == 4'd8) begin
                if (state_q == ST_DEV && sh_q[DW-1:1] != {ID_PREFIX, strap_i}) begin
                  state_q <= ST_IDLE;
                end else begin
                  oe_q  <= 1'b1;
                  ack_q <= 1'b1;
                  if (state_q == ST_DEV)  rw_q  <= sh_q[0];
                  if (state_q == ST_ADDR) ptr_q <= sh_q;
                end
              end
            end else begin
              if (scl_rise && state_q == ST_WDATA) we_q <= 1'b1;
              if (scl_fall) begin
                oe_q  <= 1'b0;
                ack_q <= 1'b0;
                cnt_q <= '0;
                if (state_q == ST_DEV) begin
                  if (rw_q) begin
                    state_q <= ST_RDATA;
                    sh_q    <= rdata_i;
                    oe_q    <= ~rdata_i[DW-1];
                  end else begin
                    state_q <= ST_ADDR;
                  end
                end else if (state_q == ST_ADDR) begin
                  state_q <= ST_WDATA;
                end else begin
                  ptr_q <= ptr_adv(ptr_q);
                end
              end
            end
          end
          ST_RDATA: begin
            if (!ack_q) begin
              if (scl_rise) begin
                cnt_q <= cnt_q + 1'b1;
              end else if (scl_fall) begin
                if (cnt_q == 4'd8) begin
                  oe_q  <= 1'b0;
                  ack_q <= 1'b1;
                end else begin
                  oe_q <= ~sh_q[DW-2];
                  sh_q <= {sh_q[DW-2:0], 1'b0};
                end
              end
            end else begin
              if (scl_rise) begin
                mack_q <= ~sda_i;
                if (!sda_i) ptr_q <= ptr_adv(ptr_q);
              end else if (scl_fall) begin
                ack_q <= 1'b0;
                if (mack_q) begin
                  sh_q  <= rdata_i;
                  oe_q  <= ~rdata_i[DW-1];
                  cnt_q <= '0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign we_o     = we_q;
  assign ptr_o    = ptr_q;
  assign wdata_o  = sh_q;
  assign sda_oe_o = oe_q;
  assign stop_o   = stop_det;
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wiper_i2c_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] wiper0_o,
  output logic [DW-1:0] wiper1_o,
  output logic [DW-1:0] ctrl_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic              scl_f, sda_f, reg_we, stop_det;
  logic [DW-1:0]     ptr, wdata, rdata;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(.STABLE(STABLE_CYC)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  assign scl_f = filt[1];
  assign sda_f = filt[0];

  i2c_wiper_engine u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (scl_f),
    .sda_i    (sda_f),
    .strap_i  (strap_i),
    .rdata_i  (rdata),
    .we_o     (reg_we),
    .ptr_o    (ptr),
    .wdata_o  (wdata),
    .sda_oe_o (sda_oe_o),
    .stop_o   (stop_det)
  );

  wiper_reg_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we),
    .addr_i   (ptr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .wiper0_o (wiper0_o),
    .wiper1_o (wiper1_o),
    .ctrl_o   (ctrl_o)
  );
endmodule

// File: rtl/wiper_i2c_checker.sv
module wiper_i2c_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_f,
  input logic       sda_oe,
  input logic       stop_det,
  input logic       we,
  input logic [7:0] waddr,
  input logic [7:0] wiper0,
  input logic [7:0] wiper1,
  input logic [7:0] ctrl
);
  assert_oe_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe) |-> !scl_f);

  assert_oe_drop_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_oe) && !stop_det && !$past(stop_det)) |-> !scl_f);

  assert_ctrl_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[7] == 1'b0 && ctrl[5:0] == 6'd0));

  assert_w0_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper0) |-> $past(we && waddr == 8'h00));

  assert_w1_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper1) |-> $past(we && waddr == 8'h01));

  assert_we_ninth_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> scl_f);

  assert_stop_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe);
endmodule

bind wiper_i2c_slave wiper_i2c_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_f    (scl_f),
  .sda_oe   (sda_oe_o),
  .stop_det (stop_det),
  .we       (reg_we),
  .waddr    (ptr),
  .wiper0   (wiper0_o),
  .wiper1   (wiper1_o),
  .ctrl     (ctrl_o)
);

// File: tb/sim_wiper_i2c_slave.sv
module sim_wiper_i2c_slave;
  localparam int Q  = 12;
  localparam int WD = 190000;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] w0, w1, ctl;
  logic sda_bus;
  int checks = 0, failures = 0;
  logic [7:0] m_w0 = 8'h80, m_w1 = 8'h80, m_ctl = 8'h40;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  wiper_i2c_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(STRAP), .sda_oe_o(sda_oe),
    .wiper0_o(w0), .wiper1_o(w1), .ctrl_o(ctl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] adv(input logic [7:0] a);
    return (a == 8'h00) ? 8'h01 : a;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_w0;
      8'h01: return m_w1;
      8'h10: return m_ctl;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void mdl_wr(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h00: m_w0 = d;
      8'h01: m_w1 = d;
      8'h10: m_ctl = d & 8'h40;
      default: ;
    endcase
  endfunction

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(Q);
    if (glitch) begin sda_m = ~b; wq(1); sda_m = b; wq(Q-1); end
    else wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit glitch, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(d[i], glitch && i == 7);
    recv_bit(s);
    ack = ~s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic s;
      recv_bit(s);
      d[i] = s;
    end
    send_bit(~mack, 1'b0);
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input bit glitch);
    bit ack;
    logic [7:0] p = a;
    bus_start();
    wr_byte({4'b1010, STRAP, 1'b0}, 1'b0, ack); chk(ack, "R1 id ack", ack, 1);
    wr_byte(a, 1'b0, ack); chk(ack, "R4 addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      if (glitch) d[7] = 1'b1;
      wr_byte(d, glitch, ack); chk(ack, "R4 data ack", ack, 1);
      mdl_wr(p, d);
      p = adv(p);
    end
    bus_stop();
    chk(w0 == m_w0, "R5 wiper0 after write", w0, m_w0);
    chk(w1 == m_w1, "R6 wiper1 after write", w1, m_w1);
    chk(ctl == m_ctl, "R3 ctrl after write", ctl, m_ctl);
  endtask

  task automatic do_read(input logic [7:0] a, input int n);
    bit ack;
    logic [7:0] p = a, d;
    bus_start();
    wr_byte({4'b1010, STRAP, 1'b0}, 1'b0, ack); chk(ack, "R1 id ack", ack, 1);
    wr_byte(a, 1'b0, ack); chk(ack, "R2 addr ack", ack, 1);
    bus_start();
    wr_byte({4'b1010, STRAP, 1'b1}, 1'b0, ack); chk(ack, "R7 read id ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n-1, d);
      chk(d == exp_rd(p), "R7 read data", d, exp_rd(p));
      p = adv(p);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ack;
    void'($urandom(32'd4711));
    wq(5); rst_n = 1'b1; wq(5);
    chk(w0 == 8'h80, "R3 reset wiper0", w0, 8'h80);
    chk(w1 == 8'h80, "R3 reset wiper1", w1, 8'h80);
    chk(ctl == 8'h40, "R3 reset ctrl", ctl, 8'h40);
    chk(sda_oe == 1'b0, "R3 reset sda idle", sda_oe, 0);

    do_read(8'h10, 1);                    // R3 ctrl reads 40h
    do_write(8'h10, 1, 1'b0);             // R3 mask
    do_write(8'h00, 3, 1'b0);             // R6 00,01,01
    do_read(8'h00, 4);                    // R7 00,01,01,01
    do_write(8'h37, 1, 1'b0);             // R2 unmapped write ignored
    do_read(8'h37, 2);                    // R2 unmapped reads 00h

    // R1: mismatching strap, no ACK, nothing written
    bus_start();
    wr_byte({4'b1010, ~STRAP, 1'b0}, 1'b0, ack);
    chk(!ack, "R1 mismatch nack", ack, 0);
    wr_byte(8'h00, 1'b0, ack); chk(!ack, "R1 ignored after mismatch", ack, 0);
    wr_byte(8'h11, 1'b0, ack);
    bus_stop();
    chk(w0 == m_w0, "R1 wiper0 untouched", w0, m_w0);

    // R9: bytes after STOP without START are ignored
    wr_byte({4'b1010, STRAP, 1'b0}, 1'b0, ack);
    chk(!ack, "R9 no ack without start", ack, 0);
    wr_byte(8'h00, 1'b0, ack);
    wr_byte(8'h22, 1'b0, ack);
    bus_stop();
    chk(w0 == m_w0, "R9 wiper0 untouched", w0, m_w0);

    // R10: one-cycle SDA spike while SCL high inside a data byte
    do_write(8'h01, 1, 1'b1);
    do_read(8'h01, 1);

    for (int t = 0; t < 24; t++) begin
      int r = int'($urandom % 5);
      logic [7:0] a = (r == 0) ? 8'h00 : (r == 1) ? 8'h01 : (r == 2) ? 8'h10 :
                      (r == 3) ? 8'($urandom) : 8'h00;
      int n = 1 + int'($urandom % 3);
      if ($urandom % 2) do_write(a, n, 1'b0);
      else do_read(a, n);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule